// File: doc/BRIEF.md
# Dual-Clock FIFO with Strap-Selected Read Timing

This block carries 36-bit words from a producer running on clock A to a consumer running on clock B. The two clocks may be unrelated or the same. Each side has a chip select (active LOW) and an enable (active HIGH). A word moves only on a rising edge of that side's clock, and only when the side is selected and enabled. Write and read pointers cross between the domains in Gray code through two-flop synchronizers. Because of this, each side's view of the other side lags by a few cycles.

A strap input, `timing_std`, is captured while the read-side reset is held and is ignored afterwards. HIGH selects standard timing: the read flag reports "not empty", and a read places the next word on `dout_b` after the edge. LOW selects fall-through timing: the oldest word is presented on `dout_b` on its own, the read flag reports "output ready", and a read consumes the presented word.

Two threshold flags sit alongside. Almost-empty is on the read clock and compares the number of words held against `ofs_ae`. Almost-full is on the write clock and compares the free storage locations against `ofs_af`. The offsets are plain inputs that stay stable once reset has been released.

Top module: `xfifo_dualclk`

## Requirements
- R1: Words leave port B in the order they were accepted on port A, with all 36 bits unchanged, including when both ports run at once on different clocks.
- R2: `timing_std` is captured during read-side reset. Changing it afterwards has no effect on read timing until the next reset.
- R3: Standard timing (`timing_std`=1): `rd_flag` is HIGH when at least one word is stored. A read accepted at a clock B edge updates `dout_b` at that edge. Without a read, `dout_b` holds its value.
- R4: Fall-through timing (`timing_std`=0): once a word reaches an idle output stage, it appears on `dout_b` with `rd_flag` HIGH, with no read request. A read while `rd_flag` is HIGH consumes it, and `rd_flag` falls if nothing else is stored.
- R5: `wr_flag` is LOW when all 2^ADDR_W storage locations are occupied. Writes attempted while it is LOW are discarded.
- R6: A read attempted while `rd_flag` is LOW changes nothing. Later data still arrives intact and in order.
- R7: `ae_n` is LOW when the number of words held (stored words, plus the presented word in fall-through timing) is less than or equal to `ofs_ae`, and HIGH otherwise, after the synchronizer lag.
- R8: `af_n` is LOW when the number of free storage locations is less than or equal to `ofs_af`, and HIGH otherwise, after the synchronizer lag.
- R9: After reset, the outputs are: `rd_flag`=0, `wr_flag`=1, `ae_n`=0, `af_n`=1 and `dout_b`=0.
- R10: A port transfers only when its chip select is LOW and its enable is HIGH at the clock edge. Any other combination moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a_n | input | 1 | Write-side synchronous reset, active LOW |
| cs_a_n | input | 1 | Write-side chip select, active LOW |
| en_a | input | 1 | Write enable, active HIGH |
| din_a | input | 36 | Write data |
| wr_flag | output | 1 | HIGH when a write can be accepted (not full / input ready) |
| af_n | output | 1 | Almost-full, active LOW |
| ofs_af | input | ADDR_W+1 | Almost-full offset (free locations) |
| clk_b | input | 1 | Read-side clock |
| rst_b_n | input | 1 | Read-side synchronous reset, active LOW |
| cs_b_n | input | 1 | Read-side chip select, active LOW |
| en_b | input | 1 | Read enable, active HIGH |
| timing_std | input | 1 | Timing strap: 1 = standard, 0 = fall-through |
| dout_b | output | 36 | Read data |
| rd_flag | output | 1 | Standard: not empty. Fall-through: output ready |
| ae_n | output | 1 | Almost-empty, active LOW |
| ofs_ae | input | ADDR_W+1 | Almost-empty offset (held words) |

## Verification
The hardest state to reach from the ports is a completely full array that is then offered further writes. The discarded words only show up as absent when the array is drained much later. The stimulus fills the array with no reads running. It steps through the almost-full boundary one word at a time and checks `af_n` after each step. It then forces writes of distinctive words while `wr_flag` is LOW, drains the array, and checks that exactly the 2^ADDR_W expected words come out and `rd_flag` then stays LOW. The strap is also changed after reset in both phases, and the bench checks that the read timing stays as captured.

// File: rtl/xfifo_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package xfifo_pkg;
    // Read timing selected by the strap at reset.
    typedef enum logic {
        TM_FWFT = 1'b0,
        TM_STD  = 1'b1
    } tmode_e;
endpackage

// File: rtl/xfifo_sync.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes: the input changes at most one bit per source clock.
module xfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xfifo_mem.sv
// Storage array: one synchronous write port, one combinational read port.
// Assumes: the controllers never write a slot the reader is about to use.
module xfifo_mem #(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word on the write clock.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the slot at the read pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
// Write-side controller: pointer, full detection, almost-full flag.
// Assumes: rgray_s is the read Gray pointer already synchronized to clk.
module xfifo_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW:0]   rgray_s,
    input  logic [AW:0]   ofs_af,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          wr_flag,
    output logic          af_n
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    logic [AW:0] wbin;
    logic [AW:0] wbin_nx;
    logic [AW:0] rbin_s;
    logic [AW:0] used;
    logic [AW:0] free;
    logic        full;

    // Convert the synchronized read pointer back to binary.
    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    // Occupancy as seen from the write side.
    always_comb begin
        used    = wbin - rbin_s;
        free    = FULL_CNT - used;
        full    = (used == FULL_CNT);
        wbin_nx = wbin + 1'b1;
    end

    assign we      = req && !full;
    assign waddr   = wbin[AW-1:0];
    assign wr_flag = !full;

    // Advance the pointer on an accepted write and refresh almost-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            af_n  <= 1'b1;
        end else begin
            if (we) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            af_n <= !(free <= ofs_af);
        end
    end

    // R1: the published pointer changes by at most one bit per edge.
    a_r1_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));
    // R5: occupancy never exceeds the array size.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        used <= FULL_CNT);
    // R5: a write offered while full leaves the pointer unchanged.
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_flag) |=> $stable(wgray));
endmodule

// File: rtl/xfifo_rd_ctl.sv
// Read-side controller: timing strap capture, pointer, output stage,
// empty / output-ready flag and almost-empty flag.
// Assumes: wgray_s is the write Gray pointer synchronized to clk; the
// strap is valid while rst_n is LOW.
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          req,
    input  logic [AW:0]   wgray_s,
    input  logic [AW:0]   ofs_ae,
    input  logic [DW-1:0] rdata_mem,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          rd_flag,
    output logic          ae_n
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    tmode_e      mode_q;
    logic [AW:0] rbin;
    logic [AW:0] rbin_nx;
    logic [AW:0] wbin_s;
    logic [AW:0] mem_cnt;
    logic [AW:0] held;
    logic        has_mem;
    logic        out_valid;
    logic        pop;

    // Capture the strap while reset is held; keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= tmode_e'(mode_i);
        end
    end

    // Convert the synchronized write pointer back to binary.
    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    // Decide when a word leaves the array, per timing mode.
    always_comb begin
        mem_cnt = wbin_s - rbin;
        has_mem = (mem_cnt != '0);
        held    = mem_cnt + {{AW{1'b0}}, out_valid};
        rbin_nx = rbin + 1'b1;
        if (mode_q == TM_STD) begin
            pop = req && has_mem;
        end else begin
            pop = has_mem && (!out_valid || req);
        end
    end

    assign raddr   = rbin[AW-1:0];
    assign rd_flag = (mode_q == TM_STD) ? has_mem : out_valid;

    // Move the pointer, load the output stage, refresh almost-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rgray     <= '0;
            dout      <= '0;
            out_valid <= 1'b0;
            ae_n      <= 1'b0;
        end else begin
            if (pop) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
                dout  <= rdata_mem;
            end
            out_valid <= (mode_q == TM_FWFT) && (pop || (out_valid && !req));
            ae_n      <= !(held <= ofs_ae);
        end
    end

    // R2: the captured mode never changes outside reset.
    a_r2_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
    // R3: in standard timing the output holds unless a read is granted.
    a_r3_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_STD && !(req && rd_flag)) |=> $stable(dout));
    // R4: a presented word stays presented until it is read.
    a_r4_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_FWFT && rd_flag && !req) |=> (rd_flag && $stable(dout)));
    // R6: the read side never sees more words than the array holds.
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cnt <= FULL_CNT);
endmodule

// File: rtl/xfifo_dualclk.sv
// Dual-clock FIFO top: write port on clk_a, read port on clk_b, Gray
// pointers crossing through two-flop synchronizers.
// Assumes: offsets are stable after reset; timing_std is valid during
// rst_b_n LOW; the array depth is a power of two.
module xfifo_dualclk #(
    parameter int DW     = 36,
    parameter int ADDR_W = 4
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              cs_a_n,
    input  logic              en_a,
    input  logic [DW-1:0]     din_a,
    output logic              wr_flag,
    output logic              af_n,
    input  logic [ADDR_W:0]   ofs_af,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              cs_b_n,
    input  logic              en_b,
    input  logic              timing_std,
    output logic [DW-1:0]     dout_b,
    output logic              rd_flag,
    output logic              ae_n,
    input  logic [ADDR_W:0]   ofs_ae
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_s;
    logic [PW-1:0]     rgray_s;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DW-1:0]     rdata;
    logic              we;
    logic              wr_req;
    logic              rd_req;

    assign wr_req = !cs_a_n && en_a;
    assign rd_req = !cs_b_n && en_b;

    xfifo_mem #(.DW(DW), .AW(ADDR_W)) mem_i (
        .clk   (clk_a),
        .we    (we),
        .waddr (waddr),
        .wdata (din_a),
        .raddr (raddr),
        .rdata (rdata)
    );

    xfifo_sync #(.W(PW)) sync_w2r_i (
        .clk   (clk_b),
        .rst_n (rst_b_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    xfifo_sync #(.W(PW)) sync_r2w_i (
        .clk   (clk_a),
        .rst_n (rst_a_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    xfifo_wr_ctl #(.AW(ADDR_W)) wr_i (
        .clk     (clk_a),
        .rst_n   (rst_a_n),
        .req     (wr_req),
        .rgray_s (rgray_s),
        .ofs_af  (ofs_af),
        .wgray   (wgray),
        .waddr   (waddr),
        .we      (we),
        .wr_flag (wr_flag),
        .af_n    (af_n)
    );

    xfifo_rd_ctl #(.DW(DW), .AW(ADDR_W)) rd_i (
        .clk       (clk_b),
        .rst_n     (rst_b_n),
        .mode_i    (timing_std),
        .req       (rd_req),
        .wgray_s   (wgray_s),
        .ofs_ae    (ofs_ae),
        .rdata_mem (rdata),
        .raddr     (raddr),
        .rgray     (rgray),
        .dout      (dout_b),
        .rd_flag   (rd_flag),
        .ae_n      (ae_n)
    );
endmodule

// File: tb/xfifo_dualclk_tb_top.sv
module xfifo_dualclk_tb_top;
    localparam int DW    = 36;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_a_n = 1'b0;
    logic          rst_b_n = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          en_a = 1'b0;
    logic [DW-1:0] din_a = '0;
    logic          cs_b_n = 1'b1;
    logic          en_b = 1'b0;
    logic          timing_std = 1'b1;
    logic [AW:0]   ofs_ae = 5'd3;
    logic [AW:0]   ofs_af = 5'd2;
    logic          wr_flag;
    logic          af_n;
    logic [DW-1:0] dout_b;
    logic          rd_flag;
    logic          ae_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] sb_q[$];

    always #2 clk_a = ~clk_a;   // 250 MHz
    always #3 clk_b = ~clk_b;   // unrelated read clock

    xfifo_dualclk #(.DW(DW), .ADDR_W(AW)) dut_i (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a_n(cs_a_n), .en_a(en_a),
        .din_a(din_a), .wr_flag(wr_flag), .af_n(af_n), .ofs_af(ofs_af),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b_n(cs_b_n), .en_b(en_b),
        .timing_std(timing_std), .dout_b(dout_b), .rd_flag(rd_flag),
        .ae_n(ae_n), .ofs_ae(ofs_ae)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_a(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(negedge clk_b);
    endtask

    task automatic do_reset(input logic strap);
        timing_std = strap;
        rst_a_n = 1'b0;
        rst_b_n = 1'b0;
        wait_b(6);
        @(negedge clk_a) rst_a_n = 1'b1;
        @(negedge clk_b) rst_b_n = 1'b1;
        sb_q.delete();
    endtask

    // Driver: writes n words when wr_flag allows, pushing expectations.
    task automatic wr_stream(input int n, input logic [DW-1:0] base);
        int i = 0;
        while (i < n) begin
            @(negedge clk_a);
            if (wr_flag) begin
                cs_a_n = 1'b0; en_a = 1'b1;
                din_a  = base + DW'(i) * 36'h1_0101_0101;
                sb_q.push_back(din_a);
                i++;
            end else begin
                en_a = 1'b0;
            end
        end
        @(negedge clk_a) begin cs_a_n = 1'b1; en_a = 1'b0; end
    endtask

    // Drive a write regardless of flags; nothing expected.
    task automatic wr_force(input logic [DW-1:0] v);
        @(negedge clk_a) begin cs_a_n = 1'b0; en_a = 1'b1; din_a = v; end
        @(negedge clk_a) begin cs_a_n = 1'b1; en_a = 1'b0; end
    endtask

    // Monitor: reads n words in the active timing mode and compares.
    task automatic rd_words(input int n, input bit std, input string req);
        int got = 0;
        int idle = 0;
        logic [DW-1:0] exp;
        while (got < n && idle < 400) begin
            @(negedge clk_b);
            if (rd_flag) begin
                idle = 0;
                exp = (sb_q.size() != 0) ? sb_q.pop_front() : '0;
                if (std) begin
                    cs_b_n = 1'b0; en_b = 1'b1;
                    @(negedge clk_b) begin cs_b_n = 1'b1; en_b = 1'b0; end
                    chk(dout_b == exp, req, dout_b, exp);
                end else begin
                    chk(dout_b == exp, req, dout_b, exp);
                    cs_b_n = 1'b0; en_b = 1'b1;
                    @(negedge clk_b) begin cs_b_n = 1'b1; en_b = 1'b0; end
                end
                got++;
            end else begin
                idle++;
            end
        end
        chk(got == n, req, DW'(got), DW'(n));
    endtask

    initial begin
        #150000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%h exp=%h", 36'h0, 36'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // ---------------- standard timing phase ----------------
        do_reset(1'b1);
        wait_b(2);
        chk(rd_flag == 1'b0, "R9 rd_flag", DW'(rd_flag), 36'h0);
        chk(wr_flag == 1'b1, "R9 wr_flag", DW'(wr_flag), 36'h1);
        chk(ae_n == 1'b0,    "R9 ae_n",    DW'(ae_n),    36'h0);
        chk(af_n == 1'b1,    "R9 af_n",    DW'(af_n),    36'h1);
        chk(dout_b == '0,    "R9 dout_b",  dout_b,       36'h0);

        // R2: strap changes after reset; read timing stays standard (R3)
        timing_std = 1'b0;
        wr_stream(1, 36'hA_5A5A_5A5A);
        wait_b(12);
        chk(rd_flag == 1'b1, "R3 not-empty flag", DW'(rd_flag), 36'h1);
        chk(dout_b == '0, "R2 no fall-through after strap change", dout_b, 36'h0);
        rd_words(1, 1'b1, "R3 read data");
        wait_b(8);
        chk(rd_flag == 1'b0, "R3 empty after read", DW'(rd_flag), 36'h0);

        // R10: deselected or disabled writes move nothing
        @(negedge clk_a) begin cs_a_n = 1'b1; en_a = 1'b1; din_a = 36'h1_2345_6789; end
        wait_a(3);
        @(negedge clk_a) begin cs_a_n = 1'b0; en_a = 1'b0; end
        wait_a(3);
        @(negedge clk_a) cs_a_n = 1'b1;
        wait_b(12);
        chk(rd_flag == 1'b0, "R10 gated write", DW'(rd_flag), 36'h0);

        // R6: reads while empty are ignored
        @(negedge clk_b) begin cs_b_n = 1'b0; en_b = 1'b1; end
        wait_b(5);
        @(negedge clk_b) begin cs_b_n = 1'b1; en_b = 1'b0; end
        chk(dout_b == 36'hA_5A5A_5A5A, "R6 dout unchanged", dout_b, 36'hA_5A5A_5A5A);
        wr_stream(2, 36'h3_0000_0010);
        wait_b(12);
        rd_words(2, 1'b1, "R6 after empty reads");

        // R7: almost-empty boundary at offset 3
        wr_stream(3, 36'h7_0000_0100);
        wait_b(12);
        chk(ae_n == 1'b0, "R7 held=3", DW'(ae_n), 36'h0);
        wr_stream(1, 36'h7_0000_0200);
        wait_b(12);
        chk(ae_n == 1'b1, "R7 held=4", DW'(ae_n), 36'h1);
        rd_words(1, 1'b1, "R7 read one");
        wait_b(6);
        chk(ae_n == 1'b0, "R7 back to 3", DW'(ae_n), 36'h0);
        rd_words(3, 1'b1, "R7 drain");

        // R8 / R5: fill to the brim
        wait_b(10);
        wr_stream(DEPTH - 3, 36'h9_0000_1000);
        wait_a(12);
        chk(af_n == 1'b1, "R8 free=3", DW'(af_n), 36'h1);
        wr_stream(1, 36'h9_0000_2000);
        wait_a(12);
        chk(af_n == 1'b0, "R8 free=2", DW'(af_n), 36'h0);
        wr_stream(2, 36'h9_0000_3000);
        wait_a(12);
        chk(wr_flag == 1'b0, "R5 full", DW'(wr_flag), 36'h0);
        wr_force(36'hF_DEAD_0001);
        wr_force(36'hF_DEAD_0002);
        wr_force(36'hF_DEAD_0003);
        rd_words(DEPTH, 1'b1, "R5 drain full");
        wait_b(15);
        chk(rd_flag == 1'b0, "R5 extra writes discarded", DW'(rd_flag), 36'h0);
        chk(wr_flag == 1'b1, "R5 space again", DW'(wr_flag), 36'h1);

        // R1: concurrent streaming
        fork
            wr_stream(40, 36'h5_0000_0000);
            rd_words(40, 1'b1, "R1 stream std");
        join

        // ---------------- fall-through phase ----------------
        do_reset(1'b0);
        wait_b(2);
        chk(rd_flag == 1'b0, "R9 rd_flag fwft", DW'(rd_flag), 36'h0);
        timing_std = 1'b1;
        wr_stream(1, 36'hC_0FFE_E001);
        wait_b(12);
        chk(rd_flag == 1'b1, "R4 output ready", DW'(rd_flag), 36'h1);
        chk(dout_b == 36'hC_0FFE_E001, "R4 word falls through", dout_b, 36'hC_0FFE_E001);
        rd_words(1, 1'b0, "R4 consume");
        wait_b(3);
        chk(rd_flag == 1'b0, "R4 ready drops", DW'(rd_flag), 36'h0);

        wr_stream(4, 36'hB_0000_0040);
        wait_b(12);
        chk(ae_n == 1'b1, "R7 fwft held=4", DW'(ae_n), 36'h1);
        rd_words(1, 1'b0, "R7 fwft read");
        wait_b(4);
        chk(ae_n == 1'b0, "R7 fwft held=3", DW'(ae_n), 36'h0);
        rd_words(3, 1'b0, "R4 fwft drain");

        fork
            wr_stream(40, 36'h6_0000_0000);
            rd_words(40, 1'b0, "R1 stream fwft");
        join

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule